// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a memory-mapped mailbox through which a host processor hands short commands to an embedded power-management controller and collects the results. The host drives a simple 32-bit register bus. One write to the command word carries the opcode, a 4-bit sub-opcode, the payload length in bytes and a flag that asks for an interrupt on completion. Before issuing the command, the host stages up to 16 payload bytes in an outbound buffer. Afterwards it polls a status word, or waits for the interrupt, and then reads up to four result words from an inbound buffer.

On the controller side the block holds a doorbell level high while a command is outstanding, together with the decoded command fields. The controller reads the outbound buffer through an index port and writes results into the inbound buffer through a write port. It finishes a command with a done strobe that carries an 8-bit result code. A command that asks for more payload than the buffer holds is never forwarded to the controller; the block completes it on the spot with an "invalid" code. Two pointer registers are plain host-read/write storage for the controller's own use.

Top module: `hc_mailbox`

## Requirements
- R1: After reset, every register reads zero: command, status, both pointers and both buffers. The interrupt output and the doorbell are low.
- R2: A host write to offset 0x00 while idle latches the 32-bit word. The next cycle, status bit 0 (busy) reads 1, the doorbell is high and the command word reads back unchanged. The doorbell presents the opcode from bits 7:0, the sub-opcode from bits 15:12 and the byte length from bits 23:16.
- R3: A command write that arrives while busy is dropped: the latched command and the doorbell fields keep their values.
- R4: A done strobe while busy clears busy in the next cycle. Status bits 23:16 then show the result code, and status bit 1 (error) is set exactly when that code is non-zero (0 none, 1 unsupported, 2 not serviced, 3 unable, 4 invalid, 5 failed, 6 security rejection, 7 unsigned image). A done strobe while idle changes nothing.
- R5: Status bit 2 (interrupt flag) and the interrupt output set on completion only when bit 8 of the latched command was 1. The flag then stays set until the host clears it.
- R6: A host write to status offset 0x04 with bit 2 set clears the interrupt flag. Busy, error and code ignore every host write, and a write with bit 2 clear has no effect.
- R7: An accepted command whose length field exceeds 16 does not raise the doorbell. In the next cycle it reads as complete: busy 0, error 1, code 4, and the interrupt flag is set if bit 8 was 1.
- R8: Each accepted command write clears the error bit and the code of the previous command.
- R9: Host word writes to 0x80, 0x84, 0x88 and 0x8C fill outbound words 0 to 3. The host reads them back at the same offsets, and the controller reads them through its index port in the same cycle.
- R10: Controller writes to inbound words 0 to 3 show up to the host at 0x90 to 0x9C. A byte read returns the byte at address bits 1:0 (little-endian) in bits 7:0 with zeros above. Host writes to the inbound buffer are ignored.
- R11: The pointers at 0x08 and 0x0C are 32-bit read/write. Read data appears on the cycle after the read enable, and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| h_wr_en | input | 1 | Host write strobe |
| h_rd_en | input | 1 | Host read strobe |
| h_rd_byte | input | 1 | Host read is byte-wide when 1 |
| h_addr | input | ADDR_W | Host byte address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, valid the cycle after h_rd_en |
| h_irq | output | 1 | Level completion interrupt to host |
| rq_valid | output | 1 | Doorbell: command outstanding at the controller |
| rq_opcode | output | 8 | Latched opcode |
| rq_sub | output | 4 | Latched sub-opcode |
| rq_len | output | 8 | Latched payload byte length |
| rq_obuf_idx | input | IW | Controller read index into outbound buffer |
| rq_obuf_data | output | 32 | Outbound word at rq_obuf_idx |
| rs_ibuf_we | input | 1 | Controller write strobe into inbound buffer |
| rs_ibuf_idx | input | IW | Inbound word index |
| rs_ibuf_wdata | input | 32 | Inbound write data |
| rs_done | input | 1 | Completion strobe from controller |
| rs_err_code | input | 8 | Result code carried with rs_done |

## Verification
The bench draws command words whose length field lies between 0 and 20, so in-range, exact-boundary (16) and over-length (17 to 20) commands are all exercised. Forwarding is told apart from immediate rejection through the doorbell and the error code. The interrupt request bit, the result codes 0 to 7, random payloads and random result words are varied in every trial. This separates the error-bit rule from the code field, and it separates the flag-set condition from plain completion. Directed cases add a command written while busy, a done strobe while idle, status writes with and without bit 2, and host writes aimed at the inbound buffer. Each of these must leave the observable state untouched.

// File: rtl/hcm_pkg.sv
package hcm_pkg;

  // Command word layout; field positions are decoded by the controller side
  typedef struct packed {
    logic [7:0] rsv_hi;
    logic [7:0] len;
    logic [3:0] sub;
    logic [2:0] rsv_mid;
    logic       irq_req;
    logic [7:0] opcode;
  } hcm_cmd_t;

  localparam int unsigned HCM_DW = 32;

  localparam int unsigned OFS_CMD  = 'h00;
  localparam int unsigned OFS_STS  = 'h04;
  localparam int unsigned OFS_SRC  = 'h08;
  localparam int unsigned OFS_DST  = 'h0C;
  localparam int unsigned OFS_OBUF = 'h80;
  localparam int unsigned OFS_IBUF = 'h90;

  localparam int unsigned STS_BUSY_BIT = 0;
  localparam int unsigned STS_ERR_BIT  = 1;
  localparam int unsigned STS_FLAG_BIT = 2;

  localparam logic [7:0] RC_NONE    = 8'd0;
  localparam logic [7:0] RC_INVALID = 8'd4;

endpackage

// File: rtl/hcm_rst_sync.sv
module hcm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/hcm_cmd_ctrl.sv
module hcm_cmd_ctrl
  import hcm_pkg::*;
#(
  parameter int unsigned MAX_LEN = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  hcm_cmd_t   cmd_wdata,
  input  logic       sts_clr,
  input  logic       rs_done,
  input  logic [7:0] rs_err,
  output hcm_cmd_t   cmd_q,
  output logic       busy_q,
  output logic       err_q,
  output logic [7:0] code_q,
  output logic       flag_q
);
  hcm_cmd_t   cmd_d;
  logic       busy_d, err_d, flag_d, flag_set;
  logic [7:0] code_d;
  logic       accept, too_long, finish;

  assign accept   = cmd_wr && !busy_q;
  assign too_long = cmd_wdata.len > 8'(MAX_LEN);
  assign finish   = busy_q && rs_done;

  always_comb begin
    cmd_d    = cmd_q;
    busy_d   = busy_q;
    err_d    = err_q;
    code_d   = code_q;
    flag_set = 1'b0;
    if (accept) begin
      cmd_d  = cmd_wdata;
      err_d  = 1'b0;
      code_d = RC_NONE;
      if (too_long) begin
        busy_d   = 1'b0;
        err_d    = 1'b1;
        code_d   = RC_INVALID;
        flag_set = cmd_wdata.irq_req;
      end else begin
        busy_d = 1'b1;
      end
    end else if (finish) begin
      busy_d   = 1'b0;
      err_d    = |rs_err;
      code_d   = rs_err;
      flag_set = cmd_q.irq_req;
    end
    // a completion in the same cycle as a clear wins
    flag_d = flag_set | (flag_q & ~sts_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      code_q <= '0;
      flag_q <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      busy_q <= busy_d;
      err_q  <= err_d;
      code_q <= code_d;
      flag_q <= flag_d;
    end
  end

  // R3
  drop_busy_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && cmd_wr |=> $stable(cmd_q));

  // R4
  done_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && rs_done |=> !busy_q && (code_q == $past(rs_err)));

  // R5
  flag_on_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && rs_done && cmd_q.irq_req |=> flag_q);

  // R5
  flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !sts_clr |=> flag_q);

  // R7
  overlen_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !busy_q && (cmd_wdata.len > 8'(MAX_LEN)) |=> !busy_q && err_q && (code_q == RC_INVALID));

  // R8
  accept_clears_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !busy_q && (cmd_wdata.len <= 8'(MAX_LEN)) |=> busy_q && !err_q && (code_q == 8'd0));
endmodule

// File: rtl/hcm_wbuf.sv
module hcm_wbuf #(
  parameter int unsigned WORDS = 4,
  parameter int unsigned DW    = 32,
  parameter int unsigned NRD   = 1,
  localparam int unsigned IW   = $clog2(WORDS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [IW-1:0]            widx,
  input  logic [DW-1:0]            wdata,
  input  logic [NRD-1:0][IW-1:0]   ridx,
  output logic [NRD-1:0][DW-1:0]   rdata
);
  logic [DW-1:0] mem_q [WORDS];
  logic [DW-1:0] mem_d [WORDS];

  always_comb begin
    for (int i = 0; i < WORDS; i++) begin
      mem_d[i] = mem_q[i];
    end
    if (we) mem_d[widx] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= mem_d[i];
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = mem_q[ridx[p]];
  end

  // R9, R10
  wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem_q[$past(widx)] == $past(wdata));
endmodule

// File: rtl/hcm_rd_mux.sv
module hcm_rd_mux
  import hcm_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BUF_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              rd_byte,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       cmd_word,
  input  logic [31:0]       sts_word,
  input  logic [31:0]       src_word,
  input  logic [31:0]       dst_word,
  input  logic [31:0]       obuf_word,
  input  logic [31:0]       ibuf_word,
  output logic [31:0]       rdata_q
);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(OFS_STS);
  localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(OFS_SRC);
  localparam logic [ADDR_W-1:0] A_DST  = ADDR_W'(OFS_DST);
  localparam logic [ADDR_W-1:0] A_OBUF = ADDR_W'(OFS_OBUF);
  localparam logic [ADDR_W-1:0] A_IBUF = ADDR_W'(OFS_IBUF);

  logic [31:0] word_sel, shifted, rdata_d;
  logic [ADDR_W-3:0] waddr;

  assign waddr = addr[ADDR_W-1:2];

  always_comb begin
    word_sel = '0;
    if      (waddr == A_CMD[ADDR_W-1:2]) word_sel = cmd_word;
    else if (waddr == A_STS[ADDR_W-1:2]) word_sel = sts_word;
    else if (waddr == A_SRC[ADDR_W-1:2]) word_sel = src_word;
    else if (waddr == A_DST[ADDR_W-1:2]) word_sel = dst_word;
    else if (addr[ADDR_W-1:BUF_AW] == A_OBUF[ADDR_W-1:BUF_AW]) word_sel = obuf_word;
    else if (addr[ADDR_W-1:BUF_AW] == A_IBUF[ADDR_W-1:BUF_AW]) word_sel = ibuf_word;
    shifted = word_sel >> {addr[1:0], 3'b000};
    rdata_d = rdata_q;
    if (rd_en) rdata_d = rd_byte ? {24'h0, shifted[7:0]} : word_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  // R10
  byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_byte |=> rdata_q[31:8] == 24'h0);

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata_q));
endmodule

// File: rtl/hc_mailbox.sv
module hc_mailbox
  import hcm_pkg::*;
#(
  parameter int unsigned BUF_WORDS = 4,
  parameter int unsigned ADDR_W    = 8,
  localparam int unsigned IW       = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_wr_en,
  input  logic              h_rd_en,
  input  logic              h_rd_byte,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [31:0]       h_wdata,
  output logic [31:0]       h_rdata,
  output logic              h_irq,
  output logic              rq_valid,
  output logic [7:0]        rq_opcode,
  output logic [3:0]        rq_sub,
  output logic [7:0]        rq_len,
  input  logic [IW-1:0]     rq_obuf_idx,
  output logic [31:0]       rq_obuf_data,
  input  logic              rs_ibuf_we,
  input  logic [IW-1:0]     rs_ibuf_idx,
  input  logic [31:0]       rs_ibuf_wdata,
  input  logic              rs_done,
  input  logic [7:0]        rs_err_code
);
  localparam int unsigned BUF_BYTES = BUF_WORDS * 4;
  localparam int unsigned BUF_AW    = $clog2(BUF_BYTES);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(OFS_STS);
  localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(OFS_SRC);
  localparam logic [ADDR_W-1:0] A_DST  = ADDR_W'(OFS_DST);
  localparam logic [ADDR_W-1:0] A_OBUF = ADDR_W'(OFS_OBUF);

  logic       rst_sync_n;
  logic       wr_cmd, wr_sts, wr_src, wr_dst, wr_obuf;
  hcm_cmd_t   cmd_q;
  logic       busy_q, err_q, flag_q;
  logic [7:0] code_q;
  logic [31:0] src_q, src_d, dst_q, dst_d, sts_word;
  logic [1:0][IW-1:0] ob_ridx;
  logic [1:0][31:0]   ob_rdata;
  logic [0:0][IW-1:0] ib_ridx;
  logic [0:0][31:0]   ib_rdata;

  hcm_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  assign wr_cmd  = h_wr_en && (h_addr == A_CMD);
  assign wr_sts  = h_wr_en && (h_addr == A_STS);
  assign wr_src  = h_wr_en && (h_addr == A_SRC);
  assign wr_dst  = h_wr_en && (h_addr == A_DST);
  assign wr_obuf = h_wr_en && (h_addr[ADDR_W-1:BUF_AW] == A_OBUF[ADDR_W-1:BUF_AW]);

  hcm_cmd_ctrl #(.MAX_LEN(BUF_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n),
    .cmd_wr(wr_cmd), .cmd_wdata(hcm_cmd_t'(h_wdata)),
    .sts_clr(wr_sts && h_wdata[STS_FLAG_BIT]),
    .rs_done(rs_done), .rs_err(rs_err_code),
    .cmd_q(cmd_q), .busy_q(busy_q), .err_q(err_q), .code_q(code_q), .flag_q(flag_q)
  );

  always_comb begin
    src_d = wr_src ? h_wdata : src_q;
    dst_d = wr_dst ? h_wdata : dst_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      src_q <= '0;
      dst_q <= '0;
    end else begin
      src_q <= src_d;
      dst_q <= dst_d;
    end
  end

  assign ob_ridx[0] = h_addr[BUF_AW-1:2];
  assign ob_ridx[1] = rq_obuf_idx;
  assign ib_ridx[0] = h_addr[BUF_AW-1:2];

  hcm_wbuf #(.WORDS(BUF_WORDS), .DW(32), .NRD(2)) u_obuf (
    .clk(clk), .rst_n(rst_sync_n),
    .we(wr_obuf), .widx(h_addr[BUF_AW-1:2]), .wdata(h_wdata),
    .ridx(ob_ridx), .rdata(ob_rdata)
  );

  hcm_wbuf #(.WORDS(BUF_WORDS), .DW(32), .NRD(1)) u_ibuf (
    .clk(clk), .rst_n(rst_sync_n),
    .we(rs_ibuf_we), .widx(rs_ibuf_idx), .wdata(rs_ibuf_wdata),
    .ridx(ib_ridx), .rdata(ib_rdata)
  );

  assign sts_word = {8'h00, code_q, 13'h0000, flag_q, err_q, busy_q};

  hcm_rd_mux #(.ADDR_W(ADDR_W), .BUF_AW(BUF_AW)) u_rd (
    .clk(clk), .rst_n(rst_sync_n),
    .rd_en(h_rd_en), .rd_byte(h_rd_byte), .addr(h_addr),
    .cmd_word(cmd_q), .sts_word(sts_word), .src_word(src_q), .dst_word(dst_q),
    .obuf_word(ob_rdata[0]), .ibuf_word(ib_rdata[0]),
    .rdata_q(h_rdata)
  );

  assign h_irq        = flag_q;
  assign rq_valid     = busy_q;
  assign rq_opcode    = cmd_q.opcode;
  assign rq_sub       = cmd_q.sub;
  assign rq_len       = cmd_q.len;
  assign rq_obuf_data = ob_rdata[1];

  // R7
  fwd_len_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rq_valid |-> rq_len <= 8'(BUF_BYTES));

  // R11
  ptr_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_src |=> src_q == $past(h_wdata));
endmodule

// File: tb/hc_mailbox_test.sv
module hc_mailbox_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        h_wr_en, h_rd_en, h_rd_byte;
  logic [7:0]  h_addr;
  logic [31:0] h_wdata;
  logic [31:0] h_rdata;
  logic        h_irq, rq_valid;
  logic [7:0]  rq_opcode, rq_len;
  logic [3:0]  rq_sub;
  logic [1:0]  rq_obuf_idx;
  logic [31:0] rq_obuf_data;
  logic        rs_ibuf_we;
  logic [1:0]  rs_ibuf_idx;
  logic [31:0] rs_ibuf_wdata;
  logic        rs_done;
  logic [7:0]  rs_err_code;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // bench model
  logic        m_busy, m_err, m_flag;
  logic [7:0]  m_code;
  logic [31:0] m_cmd;
  logic [31:0] m_obuf [4];
  logic [31:0] m_ibuf [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  hc_mailbox uut (
    .clk(clk), .rst_n(rst_n),
    .h_wr_en(h_wr_en), .h_rd_en(h_rd_en), .h_rd_byte(h_rd_byte),
    .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq),
    .rq_valid(rq_valid), .rq_opcode(rq_opcode), .rq_sub(rq_sub), .rq_len(rq_len),
    .rq_obuf_idx(rq_obuf_idx), .rq_obuf_data(rq_obuf_data),
    .rs_ibuf_we(rs_ibuf_we), .rs_ibuf_idx(rs_ibuf_idx), .rs_ibuf_wdata(rs_ibuf_wdata),
    .rs_done(rs_done), .rs_err_code(rs_err_code)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_sts();
    return {8'h00, m_code, 13'h0000, m_flag, m_err, m_busy};
  endfunction

  function automatic logic [31:0] exp_byte(input logic [31:0] w, input logic [1:0] b);
    return {24'h0, 8'(w >> (8 * b))};
  endfunction

  task automatic hwr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    h_wr_en = 1'b1; h_addr = a; h_wdata = d;
    @(negedge clk);
    h_wr_en = 1'b0;
  endtask

  task automatic hrd(input logic [7:0] a, input logic bt, output logic [31:0] d);
    @(negedge clk);
    h_rd_en = 1'b1; h_addr = a; h_rd_byte = bt;
    @(negedge clk);
    h_rd_en = 1'b0; h_rd_byte = 1'b0;
    d = h_rdata;
  endtask

  task automatic send_cmd(input logic [31:0] c);
    hwr(8'h00, c);
    if (!m_busy) begin
      m_cmd  = c;
      m_err  = 1'b0;
      m_code = 8'd0;
      if (c[23:16] > 8'd16) begin
        m_err  = 1'b1;
        m_code = 8'd4;
        if (c[8]) m_flag = 1'b1;
      end else begin
        m_busy = 1'b1;
      end
    end
  endtask

  task automatic sts_write(input logic [31:0] d);
    hwr(8'h04, d);
    if (d[2]) m_flag = 1'b0;
  endtask

  task automatic resp_done(input logic [7:0] code);
    @(negedge clk);
    rs_done = 1'b1; rs_err_code = code;
    @(negedge clk);
    rs_done = 1'b0;
    if (m_busy) begin
      m_busy = 1'b0;
      m_err  = (code != 8'd0);
      m_code = code;
      if (m_cmd[8]) m_flag = 1'b1;
    end
  endtask

  task automatic resp_wr(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    rs_ibuf_we = 1'b1; rs_ibuf_idx = idx; rs_ibuf_wdata = d;
    @(negedge clk);
    rs_ibuf_we = 1'b0;
    m_ibuf[idx] = d;
  endtask

  task automatic check_sts(input string tag);
    logic [31:0] d;
    hrd(8'h04, 1'b0, d);
    chk({tag, " status"}, d, exp_sts());
    chk({tag, " irq"}, {31'h0, h_irq}, {31'h0, m_flag});
    chk({tag, " doorbell"}, {31'h0, rq_valid}, {31'h0, m_busy});
  endtask

  task automatic check_doorbell(input string tag);
    chk({tag, " opcode"}, {24'h0, rq_opcode}, {24'h0, m_cmd[7:0]});
    chk({tag, " sub"}, {28'h0, rq_sub}, {28'h0, m_cmd[15:12]});
    chk({tag, " len"}, {24'h0, rq_len}, {24'h0, m_cmd[23:16]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R1 watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, c, p;
    int unsigned seed_sink;
    int len, k;
    seed_sink = $urandom(32'h5EED_0042);
    h_wr_en = 0; h_rd_en = 0; h_rd_byte = 0; h_addr = '0; h_wdata = '0;
    rq_obuf_idx = '0; rs_ibuf_we = 0; rs_ibuf_idx = '0; rs_ibuf_wdata = '0;
    rs_done = 0; rs_err_code = '0;
    m_busy = 0; m_err = 0; m_flag = 0; m_code = '0; m_cmd = '0;
    for (int i = 0; i < 4; i++) begin m_obuf[i] = '0; m_ibuf[i] = '0; end

    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    check_sts("R1");
    hrd(8'h00, 1'b0, d); chk("R1 cmd", d, 32'h0);
    hrd(8'h08, 1'b0, d); chk("R1 src", d, 32'h0);
    hrd(8'h0C, 1'b0, d); chk("R1 dst", d, 32'h0);
    hrd(8'h84, 1'b0, d); chk("R1 obuf", d, 32'h0);
    hrd(8'h9C, 1'b0, d); chk("R1 ibuf", d, 32'h0);

    // R11 pointers and unmapped
    hwr(8'h08, 32'hA5A5_1234);
    hwr(8'h0C, 32'h0F0F_F0F0);
    hrd(8'h08, 1'b0, d); chk("R11 src", d, 32'hA5A5_1234);
    hrd(8'h0C, 1'b0, d); chk("R11 dst", d, 32'h0F0F_F0F0);
    hrd(8'h40, 1'b0, d); chk("R11 unmapped", d, 32'h0);

    // R7 over-length with interrupt request
    send_cmd({8'h00, 8'd17, 4'h3, 3'b000, 1'b1, 8'hEE});
    chk("R7 no doorbell", {31'h0, rq_valid}, 32'h0);
    check_sts("R7");
    // R6 write without bit 2, then with all bits
    sts_write(32'hFFFF_FFFB);
    check_sts("R6 no-clear");
    sts_write(32'hFFFF_FFFF);
    check_sts("R6 clear");

    // R8 error cleared at accept, R2 boundary length 16
    send_cmd({8'h00, 8'd16, 4'h9, 3'b000, 1'b0, 8'hF0});
    check_sts("R8");
    check_doorbell("R2 len16");
    // R3 dropped write while busy
    send_cmd({8'h00, 8'd2, 4'h1, 3'b000, 1'b1, 8'h11});
    hrd(8'h00, 1'b0, d); chk("R3 cmd kept", d, m_cmd);
    check_doorbell("R3");
    resp_done(8'd0);
    check_sts("R4 ok");
    // R4 done while idle ignored
    resp_done(8'd5);
    check_sts("R4 idle done");

    for (int it = 0; it < 40; it++) begin
      for (int w = 0; w < 4; w++) begin
        p = $urandom;
        hwr(8'h80 + 8'(w * 4), p);
        m_obuf[w] = p;
      end
      k = $urandom % 4;
      hrd(8'h80 + 8'(k * 4), 1'b0, d); chk("R9 host obuf", d, m_obuf[k]);
      len = $urandom % 21;
      c = {8'($urandom), 8'(len), 4'($urandom), 3'($urandom), 1'($urandom), 8'($urandom)};
      send_cmd(c);
      chk("R2 R7 doorbell", {31'h0, rq_valid}, {31'h0, m_busy});
      check_sts("R2 R7 accept");
      if (m_busy) begin
        check_doorbell("R2");
        hrd(8'h00, 1'b0, d); chk("R2 cmd readback", d, m_cmd);
        for (int w = 0; w < 4; w++) begin
          @(negedge clk);
          rq_obuf_idx = 2'(w);
          #1;
          chk("R9 ctrl obuf", rq_obuf_data, m_obuf[w]);
        end
        if (($urandom % 4) == 0) begin
          send_cmd({8'h00, 8'd1, 4'hF, 3'b000, 1'b1, 8'h5A});
          hrd(8'h00, 1'b0, d); chk("R3 random drop", d, m_cmd);
        end
        for (int w = 0; w < 4; w++) begin
          if ($urandom % 2) resp_wr(2'(w), $urandom);
        end
        resp_done(8'($urandom % 8));
        check_sts("R4 R5 complete");
      end
      k = $urandom % 4;
      hrd(8'h90 + 8'(k * 4), 1'b0, d); chk("R10 ibuf word", d, m_ibuf[k]);
      k = $urandom % 16;
      hrd(8'h90 + 8'(k), 1'b1, d);
      chk("R10 ibuf byte", d, exp_byte(m_ibuf[k / 4], 2'(k % 4)));
      if ((it % 8) == 3) begin
        hwr(8'h94, 32'hDEAD_BEEF);
        hrd(8'h94, 1'b0, d); chk("R10 host write ignored", d, m_ibuf[1]);
      end
      if ($urandom % 2) sts_write($urandom | 32'h4);
      else              sts_write($urandom & 32'hFFFF_FFFB);
      check_sts("R6 random");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule